// File: doc/BRIEF.md
# Half-Page ECC Checker

This block generates and checks a line/column Hamming code over a flash page of 512 data bytes and 16 spare bytes. The data area is split into two halves of 256 bytes, and each half carries its own 22-bit code. The page streams through the block one byte per clock, each byte tagged with its index in the page. In program mode the block produces the code bytes for both halves, ready to be written into the spare area. In check mode it compares the stored code bytes with the recomputed ones. It then reports one of three results: a single correctable data bit (given as a byte address and bit position for a buffer writeback), a single flipped code bit, or an uncorrectable error.

A transfer begins with a start pulse that selects the mode. In check mode the pulse also selects whether the read covers the whole page or only bytes 256 to 527. The result is published after the byte at index 527 arrives. Status merging across the two halves always reports the more severe class of error.

Top module: `halfpage_ecc`

## Requirements
- R1: After reset, done_o, sbe_o, dbe_o, fix_valid_o, fix_addr_o, fix_bit_o and code_o are all zero.
- R2: In program mode, code_o = {half1 word, half0 word}. Each 24-bit word is {2'b11, code[21:0]}. Code bit 2k is the parity of all data bits in bytes whose in-half index has bit k set, and bit 2k+1 covers the bytes whose index has bit k clear (k = 0..7). Bit 16+2j covers the bits whose bit position has bit j set, and bit 17+2j covers those with bit j clear (j = 0..2). sbe_o and dbe_o stay 0.
- R3: In check mode, the stored code of half 0 is read from bytes 520 (code[7:0]), 521 (code[15:8]) and 522 (code[21:16] in bits 5:0). The code of half 1 is read from bytes 525, 526 and 527 in the same way. A page whose stored codes match reports sbe_o=0, dbe_o=0 and fix_valid_o=0.
- R4: A single flipped data bit in half h sets sbe_o, clears dbe_o and sets fix_valid_o[h]. fix_addr_o[9h+8:9h] then gives the page byte index and fix_bit_o[3h+2:3h] gives the bit position.
- R5: A single flipped stored code bit sets sbe_o and leaves dbe_o and fix_valid_o clear.
- R6: Two flipped bits in one half set dbe_o and clear sbe_o. This holds whether both bits are in data, both are in code, or one is in each.
- R7: When one half has a single error and the other has a double error, dbe_o is set and sbe_o is clear. fix_valid_o still marks the half that is correctable.
- R8: A read that covers only the upper half never reports half 0: the contents of bytes 520 to 522 have no effect, and fix_valid_o[0] stays 0.
- R9: A start pulse clears sbe_o, dbe_o and fix_valid_o one cycle later.
- R10: Bits 7:6 of stored bytes 522 and 527 are ignored on check.
- R11: done_o is a single-cycle pulse. It rises in the second cycle after the byte with index 527 is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a page transfer; latches the mode inputs |
| check_i | input | 1 | 1 = check read, 0 = program (generate) |
| upper_only_i | input | 1 | Read covers bytes 256..527 only |
| in_valid_i | input | 1 | Byte strobe |
| in_idx_i | input | 10 | Page byte index 0..527 |
| in_byte_i | input | 8 | Byte value |
| done_o | output | 1 | Result pulse |
| code_o | output | 48 | Generated code words, half 1 in the upper 24 bits |
| sbe_o | output | 1 | Corrected or code-bit single error |
| dbe_o | output | 1 | Uncorrectable error |
| fix_valid_o | output | 2 | Correction available for each half |
| fix_addr_o | output | 18 | Byte index to correct for each half (9 bits each) |
| fix_bit_o | output | 6 | Bit to flip for each half (3 bits each) |

## Verification
Within one evaluation cycle, correction of one half and detection of an uncorrectable error in the other can occur together. A page is built with one flipped data bit in half 0 and two flipped data bits in half 1. The bench then checks four things: dbe_o is set, sbe_o is suppressed, and fix_valid_o[0] is still set with the exact byte and bit of the half-0 error. A second overlap is a start pulse issued while the flags from the previous page are still set. The bench judges it by sampling the flags one cycle after the pulse.

// File: rtl/halfpage_ecc_pkg.sv
package halfpage_ecc_pkg;

  typedef enum logic [1:0] {
    SYN_CLEAN = 2'd0,
    SYN_DATA  = 2'd1,
    SYN_CODE  = 2'd2,
    SYN_MULTI = 2'd3
  } syn_cls_e;

  // bits whose position has bit j set
  function automatic logic [7:0] col_mask(input int j);
    logic [7:0] m;
    for (int t = 0; t < 8; t++) m[t] = ((t >> j) & 1) == 1;
    return m;
  endfunction

endpackage

// File: rtl/hpe_accum.sv
module hpe_accum #(
  parameter int LINE_BITS = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     clr_i,
  input  logic                     en_i,
  input  logic [LINE_BITS-1:0]     line_i,
  input  logic [7:0]               byte_i,
  output logic [2*LINE_BITS+5:0]   code_o
);
  import halfpage_ecc_pkg::*;

  logic [LINE_BITS-1:0] hi_q, lo_q;
  logic [7:0]           col_q;
  logic                 bpar;

  assign bpar = ^byte_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q  <= '0;
      lo_q  <= '0;
      col_q <= '0;
    end else if (clr_i) begin
      hi_q  <= '0;
      lo_q  <= '0;
      col_q <= '0;
    end else if (en_i) begin
      for (int k = 0; k < LINE_BITS; k++) begin
        if (line_i[k]) hi_q[k] <= hi_q[k] ^ bpar;
        else           lo_q[k] <= lo_q[k] ^ bpar;
      end
      col_q <= col_q ^ byte_i;
    end
  end

  always_comb begin
    for (int k = 0; k < LINE_BITS; k++) begin
      code_o[2*k]   = hi_q[k];
      code_o[2*k+1] = lo_q[k];
    end
    for (int j = 0; j < 3; j++) begin
      code_o[2*LINE_BITS+2*j]   = ^(col_q & col_mask(j));
      code_o[2*LINE_BITS+2*j+1] = ^(col_q & ~col_mask(j));
    end
  end

endmodule

// File: rtl/hpe_classify.sv
module hpe_classify #(
  parameter int LINE_BITS = 8
) (
  input  logic [2*LINE_BITS+5:0]      stored_i,
  input  logic [2*LINE_BITS+5:0]      calc_i,
  output halfpage_ecc_pkg::syn_cls_e  cls_o,
  output logic [LINE_BITS-1:0]        loc_byte_o,
  output logic [2:0]                  loc_bit_o
);
  import halfpage_ecc_pkg::*;

  localparam int CW    = 2*LINE_BITS + 6;
  localparam int NP    = CW / 2;
  localparam int CNT_W = $clog2(CW + 1);

  logic [CW-1:0]    syn;
  logic             all_pairs;
  logic [CNT_W-1:0] ones;

  assign syn = stored_i ^ calc_i;

  always_comb begin
    all_pairs = 1'b1;
    ones      = '0;
    for (int p = 0; p < NP; p++) all_pairs = all_pairs & (syn[2*p] ^ syn[2*p+1]);
    for (int i = 0; i < CW; i++) ones = ones + {{(CNT_W-1){1'b0}}, syn[i]};
    if (syn == '0)                  cls_o = SYN_CLEAN;
    else if (all_pairs)             cls_o = SYN_DATA;
    else if (ones == CNT_W'(1))     cls_o = SYN_CODE;
    else                            cls_o = SYN_MULTI;
  end

  always_comb begin
    for (int k = 0; k < LINE_BITS; k++) loc_byte_o[k] = syn[2*k];
    for (int j = 0; j < 3; j++)         loc_bit_o[j]  = syn[2*LINE_BITS+2*j];
  end

endmodule

// File: rtl/hpe_merge.sv
module hpe_merge #(
  parameter int NH = 2
) (
  input  halfpage_ecc_pkg::syn_cls_e [NH-1:0] cls_i,
  input  logic [NH-1:0]                       chk_i,
  output logic                                sbe_o,
  output logic                                dbe_o,
  output logic [NH-1:0]                       fix_o
);
  import halfpage_ecc_pkg::*;

  logic [NH-1:0] multi, single;

  always_comb begin
    for (int h = 0; h < NH; h++) begin
      multi[h]  = chk_i[h] && (cls_i[h] == SYN_MULTI);
      single[h] = chk_i[h] && ((cls_i[h] == SYN_DATA) || (cls_i[h] == SYN_CODE));
      fix_o[h]  = chk_i[h] && (cls_i[h] == SYN_DATA);
    end
    // more severe class wins
    dbe_o = |multi;
    sbe_o = !dbe_o && (|single);
  end

endmodule

// File: rtl/halfpage_ecc.sv
module halfpage_ecc #(
  parameter int HALF_BYTES = 256,
  parameter int PAGE_BYTES = 528,
  parameter int ECC0_OFS   = 520,
  parameter int ECC1_OFS   = 525
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic        check_i,
  input  logic        upper_only_i,
  input  logic        in_valid_i,
  input  logic [9:0]  in_idx_i,
  input  logic [7:0]  in_byte_i,
  output logic        done_o,
  output logic [47:0] code_o,
  output logic        sbe_o,
  output logic        dbe_o,
  output logic [1:0]  fix_valid_o,
  output logic [17:0] fix_addr_o,
  output logic [5:0]  fix_bit_o
);
  import halfpage_ecc_pkg::*;

  localparam int NH   = 2;
  localparam int LB   = $clog2(HALF_BYTES);
  localparam int CW   = 2*LB + 6;
  localparam int EB   = (CW + 7) / 8;
  localparam int SW   = 8*EB;
  localparam int AW   = LB + 1;
  localparam int IW   = 10;
  localparam logic [IW-1:0] LAST_IDX = IW'(PAGE_BYTES - 1);

  logic check_q, upper_q, eval_q;
  logic [SW-1:0] stored_q [NH];
  logic [CW-1:0] calc     [NH];
  syn_cls_e [NH-1:0] cls;
  logic [LB-1:0] loc_byte [NH];
  logic [2:0]    loc_bit  [NH];
  logic [NH-1:0] chk_mask, fix_c;
  logic          sbe_c, dbe_c;
  logic [47:0]   code_c;
  logic [17:0]   addr_c;
  logic [5:0]    bit_c;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      check_q <= 1'b0;
      upper_q <= 1'b0;
      eval_q  <= 1'b0;
    end else begin
      if (start_i) begin
        check_q <= check_i;
        upper_q <= upper_only_i;
      end
      eval_q <= in_valid_i && !start_i && (in_idx_i == LAST_IDX);
    end
  end

  for (genvar h = 0; h < NH; h++) begin : g_half
    localparam logic [IW-1:0] LO  = IW'(h*HALF_BYTES);
    localparam logic [IW-1:0] HI  = IW'((h+1)*HALF_BYTES);
    localparam int            OFS = (h == 0) ? ECC0_OFS : ECC1_OFS;
    logic en;

    assign en = in_valid_i && !start_i && (in_idx_i >= LO) && (in_idx_i < HI);

    hpe_accum #(.LINE_BITS(LB)) u_acc (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .clr_i (start_i),
      .en_i  (en),
      .line_i(in_idx_i[LB-1:0]),
      .byte_i(in_byte_i),
      .code_o(calc[h])
    );

    for (genvar b = 0; b < EB; b++) begin : g_cap
      localparam logic [IW-1:0] SPOS = IW'(OFS + b);
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                                        stored_q[h][8*b +: 8] <= '0;
        else if (in_valid_i && check_q && in_idx_i == SPOS) stored_q[h][8*b +: 8] <= in_byte_i;
      end
    end

    hpe_classify #(.LINE_BITS(LB)) u_cls (
      .stored_i  (stored_q[h][CW-1:0]),
      .calc_i    (calc[h]),
      .cls_o     (cls[h]),
      .loc_byte_o(loc_byte[h]),
      .loc_bit_o (loc_bit[h])
    );

    assign code_c[h*SW +: SW] = {{(SW-CW){1'b1}}, calc[h]};
    assign addr_c[h*AW +: AW] = {1'(h), loc_byte[h]};
    assign bit_c[h*3 +: 3]    = loc_bit[h];
  end

  assign chk_mask = check_q ? {1'b1, !upper_q} : 2'b00;

  hpe_merge #(.NH(NH)) u_merge (
    .cls_i(cls),
    .chk_i(chk_mask),
    .sbe_o(sbe_c),
    .dbe_o(dbe_c),
    .fix_o(fix_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o      <= 1'b0;
      code_o      <= '0;
      sbe_o       <= 1'b0;
      dbe_o       <= 1'b0;
      fix_valid_o <= '0;
      fix_addr_o  <= '0;
      fix_bit_o   <= '0;
    end else begin
      done_o <= eval_q && !start_i;
      if (start_i) begin
        sbe_o       <= 1'b0;
        dbe_o       <= 1'b0;
        fix_valid_o <= '0;
      end else if (eval_q) begin
        code_o      <= code_c;
        sbe_o       <= sbe_c;
        dbe_o       <= dbe_c;
        fix_valid_o <= fix_c;
        fix_addr_o  <= addr_c;
        fix_bit_o   <= bit_c;
      end
    end
  end

endmodule

// File: rtl/halfpage_ecc_chk.sv
module halfpage_ecc_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start_i,
  input logic       done_o,
  input logic       sbe_o,
  input logic       dbe_o,
  input logic [1:0] fix_valid_o,
  input logic       check_q,
  input logic       upper_q
);

  assert_flags_exclusive_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sbe_o && dbe_o));

  assert_done_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_start_clears_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (!sbe_o && !dbe_o && fix_valid_o == 2'b00));

  assert_program_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !check_q) |-> (!sbe_o && !dbe_o));

  assert_upper_no_fix_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && check_q && upper_q) |-> !fix_valid_o[0]);

  assert_fix_flagged_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fix_valid_o != 2'b00) |-> (sbe_o || dbe_o));

endmodule

bind halfpage_ecc halfpage_ecc_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .done_o     (done_o),
  .sbe_o      (sbe_o),
  .dbe_o      (dbe_o),
  .fix_valid_o(fix_valid_o),
  .check_q    (check_q),
  .upper_q    (upper_q)
);

// File: tb/tb_halfpage_ecc.sv
module tb_halfpage_ecc;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0, check_i = 1'b0, upper_only_i = 1'b0;
  logic        in_valid_i = 1'b0;
  logic [9:0]  in_idx_i = '0;
  logic [7:0]  in_byte_i = '0;
  logic        done_o, sbe_o, dbe_o;
  logic [47:0] code_o;
  logic [1:0]  fix_valid_o;
  logic [17:0] fix_addr_o;
  logic [5:0]  fix_bit_o;

  int checks = 0;
  int fails  = 0;
  logic [7:0] pg [528];

  always #5 clk_i = ~clk_i;

  halfpage_ecc dut (.*);

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [21:0] ref_code(input int h);
    logic [21:0] c = '0;
    for (int b = 0; b < 256; b++)
      for (int t = 0; t < 8; t++)
        if (pg[h*256+b][t]) begin
          for (int k = 0; k < 8; k++) c[((b >> k) & 1) != 0 ? 2*k : 2*k+1] ^= 1'b1;
          for (int j = 0; j < 3; j++) c[16 + (((t >> j) & 1) != 0 ? 2*j : 2*j+1)] ^= 1'b1;
        end
    return c;
  endfunction

  task automatic build(input int seed);
    logic [21:0] c0, c1;
    for (int i = 0; i < 512; i++) pg[i] = 8'((i*37 + seed*11) ^ (i >> 2));
    for (int i = 512; i < 528; i++) pg[i] = 8'hFF;
    c0 = ref_code(0);
    c1 = ref_code(1);
    pg[520] = c0[7:0];  pg[521] = c0[15:8];  pg[522] = {2'b11, c0[21:16]};
    pg[525] = c1[7:0];  pg[526] = c1[15:8];  pg[527] = {2'b11, c1[21:16]};
  endtask

  task automatic run_page(input logic chk_mode, input logic upper);
    @(negedge clk_i);
    start_i = 1'b1; check_i = chk_mode; upper_only_i = upper;
    @(negedge clk_i);
    start_i = 1'b0;
    for (int i = (upper ? 256 : 0); i < 528; i++) begin
      in_valid_i = 1'b1; in_idx_i = 10'(i); in_byte_i = pg[i];
      @(negedge clk_i);
    end
    in_valid_i = 1'b0;
    @(negedge clk_i);
    chk("R11 done rises two cycles after last byte", 64'(done_o), 64'd1);
  endtask

  task automatic expect_flags(input string tag, input logic s, input logic d, input logic [1:0] fv);
    chk({tag, " sbe"}, 64'(sbe_o), 64'(s));
    chk({tag, " dbe"}, 64'(dbe_o), 64'(d));
    chk({tag, " fix_valid"}, 64'(fix_valid_o), 64'(fv));
  endtask

  task automatic t_program;
    logic [21:0] c0, c1;
    for (int s = 1; s < 4; s++) begin
      build(s);
      c0 = ref_code(0); c1 = ref_code(1);
      run_page(1'b0, 1'b0);
      chk("R2 generated code", 64'(code_o), 64'({2'b11, c1, 2'b11, c0}));
      expect_flags("R2 program flags", 1'b0, 1'b0, 2'b00);
      @(negedge clk_i);
      chk("R11 done single cycle", 64'(done_o), 64'd0);
    end
  endtask

  task automatic t_clean;
    build(5);
    run_page(1'b1, 1'b0);
    expect_flags("R3 clean read", 1'b0, 1'b0, 2'b00);
  endtask

  task automatic t_single_data(input int idx, input int bitp);
    int h;
    h = idx / 256;
    build(7);
    pg[idx][bitp] = ~pg[idx][bitp];
    run_page(1'b1, 1'b0);
    expect_flags("R4 single data", 1'b1, 1'b0, h == 1 ? 2'b10 : 2'b01);
    chk("R4 fix address", 64'(fix_addr_o[h*9 +: 9]), 64'(idx));
    chk("R4 fix bit", 64'(fix_bit_o[h*3 +: 3]), 64'(bitp));
  endtask

  task automatic t_single_code;
    build(9);
    pg[521] ^= 8'h04;
    run_page(1'b1, 1'b0);
    expect_flags("R5 code bit half0", 1'b1, 1'b0, 2'b00);
    build(9);
    pg[527] ^= 8'h10;
    run_page(1'b1, 1'b0);
    expect_flags("R5 code bit half1", 1'b1, 1'b0, 2'b00);
  endtask

  task automatic t_double;
    build(11);
    pg[10] ^= 8'h01; pg[200] ^= 8'h10;
    run_page(1'b1, 1'b0);
    expect_flags("R6 data+data", 1'b0, 1'b1, 2'b00);
    build(11);
    pg[525] ^= 8'h02; pg[526] ^= 8'h40;
    run_page(1'b1, 1'b0);
    expect_flags("R6 code+code", 1'b0, 1'b1, 2'b00);
    build(11);
    pg[300] ^= 8'h20; pg[526] ^= 8'h01;
    run_page(1'b1, 1'b0);
    expect_flags("R6 data+code", 1'b0, 1'b1, 2'b00);
  endtask

  task automatic t_mixed;
    build(13);
    pg[33] ^= 8'h08;
    pg[300] ^= 8'h01; pg[400] ^= 8'h02;
    run_page(1'b1, 1'b0);
    expect_flags("R7 single+double", 1'b0, 1'b1, 2'b01);
    chk("R7 fix address half0", 64'(fix_addr_o[8:0]), 64'd33);
    chk("R7 fix bit half0", 64'(fix_bit_o[2:0]), 64'd3);
  endtask

  task automatic t_upper;
    build(15);
    pg[520] ^= 8'hFF; pg[522] ^= 8'h03;
    run_page(1'b1, 1'b1);
    expect_flags("R8 upper read ignores half0 code", 1'b0, 1'b0, 2'b00);
    build(15);
    pg[521] ^= 8'h81;
    pg[450] ^= 8'h40;
    run_page(1'b1, 1'b1);
    expect_flags("R8 upper read single", 1'b1, 1'b0, 2'b10);
    chk("R8 fix address half1", 64'(fix_addr_o[17:9]), 64'd450);
    chk("R8 fix bit half1", 64'(fix_bit_o[5:3]), 64'd6);
  endtask

  task automatic t_pad;
    build(17);
    pg[522] &= 8'h3F; pg[527] ^= 8'hC0;
    run_page(1'b1, 1'b0);
    expect_flags("R10 pad bits ignored", 1'b0, 1'b0, 2'b00);
  endtask

  task automatic t_clear;
    build(19);
    pg[100] ^= 8'h01; pg[101] ^= 8'h01;
    run_page(1'b1, 1'b0);
    chk("R9 precondition dbe", 64'(dbe_o), 64'd1);
    @(negedge clk_i);
    start_i = 1'b1; check_i = 1'b1; upper_only_i = 1'b0;
    @(negedge clk_i);
    start_i = 1'b0;
    expect_flags("R9 start clears", 1'b0, 1'b0, 2'b00);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1 reset done", 64'(done_o), 64'd0);
    chk("R1 reset code", 64'(code_o), 64'd0);
    chk("R1 reset fix addr/bit", 64'({fix_addr_o, fix_bit_o}), 64'd0);
    expect_flags("R1 reset", 1'b0, 1'b0, 2'b00);
    rst_ni = 1'b1;
    t_program;
    t_clean;
    t_single_data(0, 0);
    t_single_data(255, 7);
    t_single_data(256, 0);
    t_single_data(511, 7);
    t_single_data(170, 5);
    t_single_code;
    t_double;
    t_mixed;
    t_upper;
    t_pad;
    t_clear;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    checks++;
    fails++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule